// File: doc/BRIEF.md
# Set LRU Replacement Tracker

This block holds the replacement state of a K-way set-associative cache. For every set it keeps an exact ranking of the ways by how recently each was used. A cache controller pulses a touch strobe with a set index and a way number on every access. The block moves that way to the most-recent position of its set on the next clock edge and leaves every other set as it was.

When a fill is needed, the controller presents the set that missed together with that set's per-way valid bits. The block returns the way to evict. An empty way is always taken first. If no way is empty, the way that has gone unused the longest is taken. The victim output is combinational from the stored state, so it is available in the same cycle that the set index is presented.

The ranking is held as one small age counter per way: age 0 is the most recent way and age K-1 is the least recent. The intended associativity is 1 to 4, because exact ordering state grows quickly with K. With one way there is nothing to choose, and the block keeps no state at all.

Top module: `lru_tracker`

## Requirements
- R1: After reset, each way w of every set holds rank w. With all ways valid, every set therefore reports way K-1 as the victim.
- R2: After a touch of way w in set s, and with all ways valid, set s does not report w as the victim (for K > 1).
- R3: On a touch, the touched way takes rank 0. Ways that were more recent than it move back one place, and ways that were less recent keep their place. With all ways valid, the victim is always the way that has gone unused the longest.
- R4: Touching the way that is already the most recent leaves the order of its set unchanged.
- R5: If any bit of the valid vector is 0 (bit w belongs to way w, and 1 means valid), the victim is a way whose bit is 0.
- R6: When several ways are invalid, the victim is the lowest-numbered invalid way.
- R7: The victim output follows the current state combinationally. A touch changes the output only after the next rising clock edge.
- R8: A touch changes no set other than the one it names.
- R9: With K = 1, the victim is always way 0, whatever the valid vector and touch activity.
- R10: While touch_en is 0, the set and way inputs have no effect on any set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| touch_en | input | 1 | Marks an access to record in this cycle |
| touch_set | input | log2(NUM_SETS) | Set of the recorded access |
| touch_way | input | max(1, log2(NUM_WAYS)) | Way of the recorded access |
| victim_set | input | log2(NUM_SETS) | Set being looked up for replacement |
| valid_vec | input | NUM_WAYS | Valid bit of each way of victim_set |
| victim_way | output | max(1, log2(NUM_WAYS)) | Way chosen for eviction |

## Verification
The assertions assume that the valid vector describes the set named by victim_set. They also assume that touch_en stays low while reset is active, and that touch_way names an existing way. The stimulus holds touch_en at 0 throughout every reset and drives only way numbers below K. It presents full and partial valid vectors for the sets it has touched, so the checks on the most-recent way and on rank K-1 are exercised against real orderings. Untouched sets are looked up alongside the touched ones, which shows that they keep their reset order.

// File: rtl/lru_pkg.sv
package lru_pkg;
   // width of an index that selects one of n items, never below one bit
   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/lru_age_step.sv
module lru_age_step
   import lru_pkg::*;
#(
   parameter int NUM_WAYS = 4,
   parameter int AGE_W    = idx_width(NUM_WAYS),
   parameter int WAY_W    = idx_width(NUM_WAYS)
) (
   input  logic [NUM_WAYS-1:0][AGE_W-1:0] ages_in,
   input  logic [WAY_W-1:0]               hit_way,
   output logic [NUM_WAYS-1:0][AGE_W-1:0] ages_out
);
   logic [AGE_W-1:0] hit_age;

   always_comb begin
      hit_age = '0;
      for (int w = 0; w < NUM_WAYS; w++) begin
         if (WAY_W'(w) == hit_way) hit_age = ages_in[w];
      end
   end

   // each way decides its own new rank from the rank the hit way held
   for (genvar g = 0; g < NUM_WAYS; g++) begin : g_way
      always_comb begin
         if (WAY_W'(g) == hit_way)
            ages_out[g] = '0;
         else if (ages_in[g] < hit_age)
            ages_out[g] = ages_in[g] + AGE_W'(1);
         else
            ages_out[g] = ages_in[g];
      end
   end
endmodule

// File: rtl/lru_victim_sel.sv
module lru_victim_sel
   import lru_pkg::*;
#(
   parameter int NUM_WAYS = 4,
   parameter int AGE_W    = idx_width(NUM_WAYS),
   parameter int WAY_W    = idx_width(NUM_WAYS)
) (
   input  logic [NUM_WAYS-1:0][AGE_W-1:0] ages,
   input  logic [NUM_WAYS-1:0]            valid,
   output logic [WAY_W-1:0]               victim
);
   localparam logic [AGE_W-1:0] OLDEST = AGE_W'(NUM_WAYS - 1);

   logic [WAY_W-1:0] lru_way;
   logic [WAY_W-1:0] empty_way;

   always_comb begin
      lru_way = '0;
      for (int w = NUM_WAYS - 1; w >= 0; w--) begin
         if (ages[w] == OLDEST) lru_way = WAY_W'(w);
      end
   end

   // scanning downwards leaves the lowest empty way as the winner
   always_comb begin
      empty_way = '0;
      for (int w = NUM_WAYS - 1; w >= 0; w--) begin
         if (!valid[w]) empty_way = WAY_W'(w);
      end
   end

   assign victim = (&valid) ? lru_way : empty_way;
endmodule

// File: rtl/lru_tracker.sv
module lru_tracker
   import lru_pkg::*;
#(
   parameter int NUM_SETS = 16,
   parameter int NUM_WAYS = 4,
   localparam int SET_W   = idx_width(NUM_SETS),
   localparam int WAY_W   = idx_width(NUM_WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             touch_en,
   input  logic [SET_W-1:0] touch_set,
   input  logic [WAY_W-1:0] touch_way,
   input  logic [SET_W-1:0] victim_set,
   input  logic [NUM_WAYS-1:0] valid_vec,
   output logic [WAY_W-1:0] victim_way
);
   localparam int  AGE_W    = idx_width(NUM_WAYS);
   localparam bit  WAYS_POW2 = (NUM_WAYS == (1 << $clog2(NUM_WAYS)));

   if (NUM_WAYS < 1 || NUM_WAYS > 4) begin : g_bad_ways
      $error("lru_tracker: NUM_WAYS must lie in 1..4");
   end
   if (NUM_SETS < 2 || NUM_SETS != (1 << $clog2(NUM_SETS))) begin : g_bad_sets
      $error("lru_tracker: NUM_SETS must be a power of two, at least 2");
   end

   if (NUM_WAYS == 1) begin : g_direct
      logic unused_inputs;
      assign unused_inputs = ^{touch_en, touch_set, touch_way, victim_set, valid_vec};
      assign victim_way    = '0;

      // R9
      single_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
         victim_way == '0);
   end else begin : g_assoc
      typedef logic [NUM_WAYS-1:0][AGE_W-1:0] rank_t;

      rank_t age_q [NUM_SETS];
      rank_t cur_ranks;
      rank_t vic_ranks;
      rank_t next_ranks;
      logic  touch_ok;
      logic [NUM_WAYS-1:0] low_mask;

      if (WAYS_POW2) begin : g_full_way_range
         assign touch_ok = touch_en;
      end else begin : g_part_way_range
         assign touch_ok = touch_en && (int'(touch_way) < NUM_WAYS);
      end

      assign cur_ranks = age_q[touch_set];
      assign vic_ranks = age_q[victim_set];

      lru_age_step #(
         .NUM_WAYS (NUM_WAYS),
         .AGE_W    (AGE_W),
         .WAY_W    (WAY_W)
      ) u_step (
         .ages_in  (cur_ranks),
         .hit_way  (touch_way),
         .ages_out (next_ranks)
      );

      lru_victim_sel #(
         .NUM_WAYS (NUM_WAYS),
         .AGE_W    (AGE_W),
         .WAY_W    (WAY_W)
      ) u_pick (
         .ages   (vic_ranks),
         .valid  (valid_vec),
         .victim (victim_way)
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int s = 0; s < NUM_SETS; s++) begin
               for (int w = 0; w < NUM_WAYS; w++) begin
                  age_q[s][w] <= AGE_W'(w);
               end
            end
         end else if (touch_ok) begin
            age_q[touch_set] <= next_ranks;
         end
      end

      assign low_mask = (NUM_WAYS'(1) << victim_way) - NUM_WAYS'(1);

      // R5
      empty_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !(&valid_vec) |-> !valid_vec[victim_way]);

      // R6
      lowest_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !(&valid_vec) |-> ((valid_vec & low_mask) == low_mask));

      // R3
      oldest_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (&valid_vec) |-> (vic_ranks[victim_way] == AGE_W'(NUM_WAYS - 1)));

      // R2
      fresh_not_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
         touch_ok |=> (victim_set != $past(touch_set)) || !(&valid_vec)
                      || (victim_way != $past(touch_way)));

      for (genvar s = 0; s < NUM_SETS; s++) begin : g_set_chk
         logic [NUM_WAYS-1:0] seen;
         always_comb begin
            seen = '0;
            for (int w = 0; w < NUM_WAYS; w++) seen[age_q[s][w]] = 1'b1;
         end

         // R3
         rank_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
            &seen);

         // R8
         other_set_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(touch_ok && touch_set == SET_W'(s)) |=> $stable(age_q[s]));
      end
   end
endmodule

// File: tb/lru_tracker_test.sv
module lru_tracker_test;
   localparam real CYC = 20.0;
   localparam int  NV  = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       touch_en = 1'b0;
   logic [3:0] touch_set = '0;
   logic [1:0] touch_way = '0;
   logic [3:0] victim_set = '0;
   logic [3:0] valid_vec = 4'hF;
   logic [1:0] victim_way;

   logic       t1_en = 1'b0;
   logic [3:0] t1_set = '0;
   logic [0:0] t1_way = '0;
   logic [0:0] v1_valid = 1'b1;
   logic [0:0] v1_way;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #(CYC/2) clk = ~clk;

   lru_tracker #(.NUM_SETS(16), .NUM_WAYS(4)) uut (
      .clk(clk), .rst_n(rst_n), .touch_en(touch_en), .touch_set(touch_set),
      .touch_way(touch_way), .victim_set(victim_set), .valid_vec(valid_vec),
      .victim_way(victim_way));

   lru_tracker #(.NUM_SETS(16), .NUM_WAYS(1)) uut1 (
      .clk(clk), .rst_n(rst_n), .touch_en(t1_en), .touch_set(t1_set),
      .touch_way(t1_way), .victim_set(t1_set), .valid_vec(v1_valid),
      .victim_way(v1_way));

   // fields: req[20:17] touch[16] tset[15:12] tway[11:10] vset[9:6] valid[5:2] expect[1:0]
   localparam logic [20:0] VEC [NV] = '{
      {4'd1,  1'b0, 4'd0, 2'd0, 4'd3, 4'hF, 2'd3},  // R1 reset order, set 3
      {4'd1,  1'b0, 4'd0, 2'd0, 4'd9, 4'hF, 2'd3},  // R1 reset order, set 9
      {4'd7,  1'b1, 4'd3, 2'd3, 4'd3, 4'hF, 2'd3},  // R7 old value before edge
      {4'd2,  1'b0, 4'd0, 2'd0, 4'd3, 4'hF, 2'd2},  // R2 way 3 now recent
      {4'd3,  1'b1, 4'd3, 2'd1, 4'd3, 4'hF, 2'd2},  // R3
      {4'd3,  1'b0, 4'd0, 2'd0, 4'd3, 4'hF, 2'd2},  // R3 order 1,3,0,2
      {4'd8,  1'b1, 4'd3, 2'd2, 4'd5, 4'hF, 2'd3},  // R8 set 5 untouched
      {4'd3,  1'b0, 4'd0, 2'd0, 4'd3, 4'hF, 2'd0},  // R3 order 2,1,3,0
      {4'd4,  1'b1, 4'd3, 2'd2, 4'd3, 4'hF, 2'd0},  // R4 retouch recent way
      {4'd4,  1'b0, 4'd0, 2'd0, 4'd3, 4'hF, 2'd0},  // R4 order kept
      {4'd2,  1'b1, 4'd3, 2'd0, 4'd3, 4'hF, 2'd0},  // R2 touch the victim
      {4'd3,  1'b0, 4'd0, 2'd0, 4'd3, 4'hF, 2'd3},  // R3 order 0,2,1,3
      {4'd5,  1'b0, 4'd0, 2'd0, 4'd3, 4'hB, 2'd2},  // R5 only way 2 empty
      {4'd6,  1'b0, 4'd0, 2'd0, 4'd3, 4'h6, 2'd0},  // R6 ways 0,3 empty
      {4'd6,  1'b0, 4'd0, 2'd0, 4'd3, 4'h8, 2'd0},  // R6 three empty
      {4'd5,  1'b0, 4'd0, 2'd0, 4'd3, 4'h7, 2'd3},  // R5 only way 3 empty
      {4'd6,  1'b0, 4'd0, 2'd0, 4'd3, 4'h5, 2'd1},  // R6 ways 1,3 empty
      {4'd10, 1'b0, 4'd3, 2'd3, 4'd3, 4'hF, 2'd3},  // R10 strobe low
      {4'd10, 1'b0, 4'd0, 2'd0, 4'd3, 4'hF, 2'd3},  // R10 still unchanged
      {4'd8,  1'b0, 4'd0, 2'd0, 4'd5, 4'hF, 2'd3}   // R8 set 5 reset order
   };

   task automatic check(input string req, input logic [1:0] got, input logic [1:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: victim=%0d expected=%0d", req, got, exp);
      end
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      #(CYC * 5000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: run did not end, expected completion");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         touch_en   = VEC[i][16];
         touch_set  = VEC[i][15:12];
         touch_way  = VEC[i][11:10];
         victim_set = VEC[i][9:6];
         valid_vec  = VEC[i][5:2];
         #2;
         check($sformatf("R%0d vec%0d", VEC[i][20:17], i), victim_way, VEC[i][1:0]);
      end

      // R7: touch of set 9 way 3, output unchanged until the edge
      @(negedge clk);
      touch_en = 1'b1; touch_set = 4'd9; touch_way = 2'd3;
      victim_set = 4'd9; valid_vec = 4'hF;
      #2 check("R7 pre-edge", victim_way, 2'd3);
      @(negedge clk);
      touch_en = 1'b0;
      #2 check("R2 after edge", victim_way, 2'd2);

      // R1: reset mid-run restores the initial order of set 3
      @(negedge clk) rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      victim_set = 4'd3;
      #2 check("R1 after reset", victim_way, 2'd3);

      // R9: single way block
      v1_valid = 1'b0;
      #2 check("R9 empty way", {1'b0, v1_way}, 2'd0);
      @(negedge clk);
      t1_en = 1'b1; v1_valid = 1'b1;
      @(negedge clk);
      t1_en = 1'b0;
      #2 check("R9 after touch", {1'b0, v1_way}, 2'd0);

      done = 1;
      finish_run();
   end
endmodule